// File: doc/BRIEF.md
# Branch-Speculation Access Gating

This block keeps two learned bits for every instruction slot of a small direct-mapped instruction cache. It uses them to decide, one fetch ahead, whether the branch predictor, the branch target buffer and the return address stack need to be powered for the next fetch. One bit covers the path where the fetch falls through to the following slot. The other covers the path where the fetched instruction is predicted taken and fetch moves to its target. A bit that is set promises that the instruction on that path behaves like a non-branch. A branch whose bimodal counter sits in the strongly-not-taken state counts as a non-branch.

Every fetch reports its slot (line and word), whether it is a transfer of control, its 2-bit bimodal state, its predicted direction, and whether it was reached through the taken path of the previous fetch. The block remembers the previous fetch slot. On the next fetch it writes what it learned into that slot's bit for the path that was taken. It drives a single registered enable, `spec_en`, that applies to the fetch after the current one. A misprediction report clears the fall-through bit of the instruction before the mispredicted branch. A line eviction clears every bit of that line. The gate does not depend on whether an instruction came from the small cache or from the level-one cache, so the block has no input for the instruction source.

Top module: `spec_gate`

## Requirements
- R1: After reset, `spec_en` is 1, all stored bits are clear and no previous fetch is remembered.
- R2: On a fetch with `fetch_taken`=0, `spec_en` in the next cycle is the inverse of that slot's fall-through bit. In a cycle with no fetch, `spec_en` keeps its value.
- R3: Slots are ordered by flat index line*WORDS+word. When a fetch arrives with `fetch_via_target`=0 and a previous fetch is remembered, the previous slot's fall-through bit is written. It is written 1 if the current instruction is not a transfer of control and 0 if it is one (except as in R4).
- R4: A transfer of control whose `fetch_bp_state` is 2'b00 (strongly not taken) is learned as a non-branch. States 2'b01, 2'b10 and 2'b11 are learned as branches.
- R5: `mispred_vld` clears the fall-through bit of the slot before the reported slot. Word 0 of a line is preceded by the last word of the previous line, and slot 0 is preceded by the last slot of the last line. The clear wins over a learning write to the same slot in the same cycle.
- R6: When a fetch arrives with `fetch_via_target`=1 and a previous fetch is remembered, the previous slot's target bit is written by the rule of R3 and R4. A fetch with `fetch_taken`=1 sets `spec_en` in the next cycle to the inverse of that slot's target bit.
- R7: The two bits of a slot are independent. A taken fetch ignores the fall-through bit, and a not-taken fetch ignores the target bit.
- R8: A fetch whose bit for its predicted path is clear (no metadata, for example the first fetch after reset or after a fill) gives `spec_en`=1.
- R9: `evict_vld` clears both bits of every word of `evict_line`. A fetch from that line in the same cycle sees the cleared bits and gives `spec_en`=1. The clear wins over a same-cycle learning write into that line.
- R10: An eviction leaves every other line untouched. This includes the last fall-through bit of the preceding line and the target bits of branches in other lines whose targets lay in the evicted line.
- R11: An eviction of the remembered previous slot's line in a cycle without a fetch forgets the previous slot, so the next fetch writes no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_vld | input | 1 | An instruction is fetched this cycle |
| fetch_line | input | LINE_W | Cache line of the fetched instruction |
| fetch_word | input | WORD_W | Word within the line |
| fetch_is_cti | input | 1 | Fetched instruction is a transfer of control |
| fetch_bp_state | input | 2 | Bimodal counter state of the fetched instruction |
| fetch_taken | input | 1 | Fetched instruction is predicted taken |
| fetch_via_target | input | 1 | This fetch follows the taken path of the previous fetch |
| mispred_vld | input | 1 | A branch misprediction is reported |
| mispred_line | input | LINE_W | Line of the mispredicted branch |
| mispred_word | input | WORD_W | Word of the mispredicted branch |
| evict_vld | input | 1 | A line is being replaced |
| evict_line | input | LINE_W | Line being replaced |
| spec_en | output | 1 | Enable for predictor, target buffer and return stack on the next fetch |

## Verification
The properties assume that `fetch_taken` is raised only for transfers of control and that `fetch_via_target` describes the transition from the previous fetch. They do not assume that a misprediction names a slot whose predecessor was actually learned. The stimulus follows the same assumptions: taken is drawn only when the transfer-of-control flag is set, while misprediction and eviction events land on arbitrary slots, including ones that coincide with fetches. Eviction slots also fall on the remembered slot, so the same-cycle priorities of R5, R9 and R11 are reached as well.

// File: rtl/spec_gate_pkg.sv
package spec_gate_pkg;

    typedef enum logic [1:0] {
        BP_STRONG_NT = 2'b00,
        BP_WEAK_NT   = 2'b01,
        BP_WEAK_T    = 2'b10,
        BP_STRONG_T  = 2'b11
    } bp_state_e;

    // An instruction counts as a non-branch for gating when it is not a
    // transfer of control or when its counter is saturated not-taken.
    function automatic logic acts_as_plain(input logic is_cti, input logic [1:0] state);
        return !is_cti || (state == BP_STRONG_NT);
    endfunction

endpackage

// File: rtl/spec_gate_meta.sv
module spec_gate_meta #(
    parameter int SLOTS = 64,
    parameter int WORDS = 4,
    localparam int LINES  = SLOTS / WORDS,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_vld,
    input  logic              wr_tgt,
    input  logic [SLOT_W-1:0] wr_idx,
    input  logic              wr_val,
    input  logic              clr_vld,
    input  logic [SLOT_W-1:0] clr_idx,
    input  logic              ev_vld,
    input  logic [LINE_W-1:0] ev_line,
    input  logic [SLOT_W-1:0] rd_idx,
    output logic              rd_ns,
    output logic              rd_nt
);

    typedef struct packed {
        logic [SLOTS-1:0] ns;
        logic [SLOTS-1:0] nt;
    } meta_t;

    meta_t meta_d, meta_q;
    logic [SLOTS-1:0] ev_mask;

    for (genvar l = 0; l < LINES; l++) begin : g_line
        assign ev_mask[l*WORDS +: WORDS] = {WORDS{ev_vld && (ev_line == LINE_W'(l))}};
    end

    always_comb begin
        meta_d = meta_q;
        if (wr_vld) begin
            if (wr_tgt) begin
                meta_d.nt[wr_idx] = wr_val;
            end else begin
                meta_d.ns[wr_idx] = wr_val;
            end
        end
        if (clr_vld) begin
            meta_d.ns[clr_idx] = 1'b0;
        end
        meta_d.ns = meta_d.ns & ~ev_mask;
        meta_d.nt = meta_d.nt & ~ev_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
        end else begin
            meta_q <= meta_d;
        end
    end

    // A line replaced this cycle carries no metadata for a same-cycle read.
    assign rd_ns = meta_q.ns[rd_idx] & ~ev_mask[rd_idx];
    assign rd_nt = meta_q.nt[rd_idx] & ~ev_mask[rd_idx];

endmodule

// File: rtl/spec_gate_track.sv
module spec_gate_track #(
    parameter int LINE_W = 4,
    parameter int WORD_W = 2,
    localparam int SLOT_W = LINE_W + WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_vld,
    input  logic [SLOT_W-1:0] fetch_idx,
    input  logic              fetch_taken,
    input  logic              rd_ns,
    input  logic              rd_nt,
    input  logic              ev_vld,
    input  logic [LINE_W-1:0] ev_line,
    output logic              prev_vld,
    output logic [SLOT_W-1:0] prev_idx,
    output logic              spec_en
);

    typedef struct packed {
        logic              prev_vld;
        logic [SLOT_W-1:0] prev_idx;
        logic              spec_en;
    } track_t;

    track_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (fetch_vld) begin
            trk_d.spec_en  = !(fetch_taken ? rd_nt : rd_ns);
            trk_d.prev_vld = 1'b1;
            trk_d.prev_idx = fetch_idx;
        end else if (ev_vld && (trk_q.prev_idx[SLOT_W-1:WORD_W] == ev_line)) begin
            trk_d.prev_vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q.prev_vld <= 1'b0;
            trk_q.prev_idx <= '0;
            trk_q.spec_en  <= 1'b1;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign prev_vld = trk_q.prev_vld;
    assign prev_idx = trk_q.prev_idx;
    assign spec_en  = trk_q.spec_en;

endmodule

// File: rtl/spec_gate.sv
module spec_gate
    import spec_gate_pkg::*;
#(
    parameter int LINES = 16,
    parameter int WORDS = 4,
    localparam int LINE_W = $clog2(LINES),
    localparam int WORD_W = $clog2(WORDS),
    localparam int SLOTS  = LINES * WORDS,
    localparam int SLOT_W = LINE_W + WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_vld,
    input  logic [LINE_W-1:0] fetch_line,
    input  logic [WORD_W-1:0] fetch_word,
    input  logic              fetch_is_cti,
    input  logic [1:0]        fetch_bp_state,
    input  logic              fetch_taken,
    input  logic              fetch_via_target,
    input  logic              mispred_vld,
    input  logic [LINE_W-1:0] mispred_line,
    input  logic [WORD_W-1:0] mispred_word,
    input  logic              evict_vld,
    input  logic [LINE_W-1:0] evict_line,
    output logic              spec_en
);

    logic [SLOT_W-1:0] fetch_idx;
    logic [SLOT_W-1:0] mis_idx;
    logic [SLOT_W-1:0] mis_pred_idx;
    logic              prev_vld;
    logic [SLOT_W-1:0] prev_idx;
    logic              rd_ns;
    logic              rd_nt;
    logic              learn_vld;
    logic              learn_val;

    assign fetch_idx    = {fetch_line, fetch_word};
    assign mis_idx      = {mispred_line, mispred_word};
    // Flat index minus one wraps word 0 to the previous line's last word.
    assign mis_pred_idx = mis_idx - SLOT_W'(1);
    assign learn_vld    = fetch_vld && prev_vld;
    assign learn_val    = acts_as_plain(fetch_is_cti, fetch_bp_state);

    spec_gate_meta #(
        .SLOTS (SLOTS),
        .WORDS (WORDS)
    ) u_meta (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_vld  (learn_vld),
        .wr_tgt  (fetch_via_target),
        .wr_idx  (prev_idx),
        .wr_val  (learn_val),
        .clr_vld (mispred_vld),
        .clr_idx (mis_pred_idx),
        .ev_vld  (evict_vld),
        .ev_line (evict_line),
        .rd_idx  (fetch_idx),
        .rd_ns   (rd_ns),
        .rd_nt   (rd_nt)
    );

    spec_gate_track #(
        .LINE_W (LINE_W),
        .WORD_W (WORD_W)
    ) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_vld   (fetch_vld),
        .fetch_idx   (fetch_idx),
        .fetch_taken (fetch_taken),
        .rd_ns       (rd_ns),
        .rd_nt       (rd_nt),
        .ev_vld      (evict_vld),
        .ev_line     (evict_line),
        .prev_vld    (prev_vld),
        .prev_idx    (prev_idx),
        .spec_en     (spec_en)
    );

endmodule

// File: rtl/spec_gate_chk.sv
module spec_gate_chk #(
    parameter int LINE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_vld,
    input logic              fetch_taken,
    input logic [LINE_W-1:0] fetch_line,
    input logic              evict_vld,
    input logic [LINE_W-1:0] evict_line,
    input logic              rd_ns,
    input logic              rd_nt,
    input logic              spec_en
);

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_vld |=> $stable(spec_en));

    // R2
    seq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_vld && !fetch_taken && rd_ns) |=> !spec_en);

    // R6
    tgt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_vld && fetch_taken && rd_nt) |=> !spec_en);

    // R8
    no_meta_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_vld && !(fetch_taken ? rd_nt : rd_ns)) |=> spec_en);

    // R9
    evict_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_vld && evict_vld && (evict_line == fetch_line)) |=> spec_en);

endmodule

bind spec_gate spec_gate_chk #(.LINE_W(LINE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_vld   (fetch_vld),
    .fetch_taken (fetch_taken),
    .fetch_line  (fetch_line),
    .evict_vld   (evict_vld),
    .evict_line  (evict_line),
    .rd_ns       (rd_ns),
    .rd_nt       (rd_nt),
    .spec_en     (spec_en)
);

// File: tb/spec_gate_tb.sv
`timescale 1ns/1ps
module spec_gate_tb;

    localparam int LINES  = 4;
    localparam int WORDS  = 4;
    localparam int LINE_W = 2;
    localparam int WORD_W = 2;
    localparam int SLOTS  = LINES * WORDS;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fetch_vld = 1'b0;
    logic [LINE_W-1:0] fetch_line = '0;
    logic [WORD_W-1:0] fetch_word = '0;
    logic              fetch_is_cti = 1'b0;
    logic [1:0]        fetch_bp_state = 2'b00;
    logic              fetch_taken = 1'b0;
    logic              fetch_via_target = 1'b0;
    logic              mispred_vld = 1'b0;
    logic [LINE_W-1:0] mispred_line = '0;
    logic [WORD_W-1:0] mispred_word = '0;
    logic              evict_vld = 1'b0;
    logic [LINE_W-1:0] evict_line = '0;
    logic              spec_en;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Reference state built from the requirements
    bit m_ns [SLOTS];
    bit m_nt [SLOTS];
    bit m_pv;
    int m_prev;
    bit m_spec;

    always #2 clk = ~clk;

    spec_gate #(.LINES(LINES), .WORDS(WORDS)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .fetch_vld(fetch_vld), .fetch_line(fetch_line), .fetch_word(fetch_word),
        .fetch_is_cti(fetch_is_cti), .fetch_bp_state(fetch_bp_state),
        .fetch_taken(fetch_taken), .fetch_via_target(fetch_via_target),
        .mispred_vld(mispred_vld), .mispred_line(mispred_line), .mispred_word(mispred_word),
        .evict_vld(evict_vld), .evict_line(evict_line), .spec_en(spec_en)
    );

    task automatic check(input string tag, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: spec_en got=%0b expected=%0b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic clear_inputs();
        fetch_vld = 0; fetch_is_cti = 0; fetch_bp_state = 0; fetch_taken = 0;
        fetch_via_target = 0; mispred_vld = 0; evict_vld = 0;
    endtask

    // One clock: model next state from current inputs, clock, compare.
    task automatic cycle(input string tag, input bit do_chk);
        int  fi;
        int  ev_l;
        int  mi;
        bit  nb;
        bit  rns;
        bit  rnt;
        bit  exp_spec;
        fi   = int'(fetch_line) * WORDS + int'(fetch_word);
        ev_l = int'(evict_line);
        mi   = int'(mispred_line) * WORDS + int'(mispred_word);
        nb   = !fetch_is_cti || (fetch_bp_state == 2'b00);
        rns  = m_ns[fi] && !(evict_vld && (ev_l == fi / WORDS));
        rnt  = m_nt[fi] && !(evict_vld && (ev_l == fi / WORDS));
        exp_spec = fetch_vld ? !(fetch_taken ? rnt : rns) : m_spec;
        if (fetch_vld && m_pv) begin
            if (fetch_via_target) m_nt[m_prev] = nb;
            else                  m_ns[m_prev] = nb;
        end
        if (mispred_vld) m_ns[(mi + SLOTS - 1) % SLOTS] = 0;
        if (evict_vld) begin
            for (int w = 0; w < WORDS; w++) begin
                m_ns[ev_l*WORDS + w] = 0;
                m_nt[ev_l*WORDS + w] = 0;
            end
        end
        if (fetch_vld) begin
            m_pv = 1; m_prev = fi;
        end else if (evict_vld && (m_prev / WORDS == ev_l)) begin
            m_pv = 0;
        end
        m_spec = exp_spec;
        @(posedge clk);
        #1;
        if (do_chk) check(tag, spec_en, exp_spec);
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic set_fetch(input int idx, input bit cti, input int st, input bit taken, input bit via);
        fetch_vld = 1;
        fetch_line = LINE_W'(idx / WORDS);
        fetch_word = WORD_W'(idx % WORDS);
        fetch_is_cti = cti;
        fetch_bp_state = 2'(st);
        fetch_taken = taken;
        fetch_via_target = via;
    endtask

    task automatic do_fetch(input int idx, input bit cti, input int st, input bit taken,
                            input bit via, input string tag, input bit chk);
        set_fetch(idx, cti, st, taken, via);
        cycle(tag, chk);
    endtask

    task automatic do_evict(input int line);
        evict_vld = 1; evict_line = LINE_W'(line);
        cycle("R9", 0);
    endtask

    task automatic do_mispred(input int idx);
        mispred_vld = 1;
        mispred_line = LINE_W'(idx / WORDS);
        mispred_word = WORD_W'(idx % WORDS);
        cycle("R5", 0);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: run did not complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < SLOTS; s++) begin m_ns[s] = 0; m_nt[s] = 0; end
        m_pv = 0; m_prev = 0; m_spec = 1;
        repeat (3) @(negedge clk);
        check("R1 reset enable", spec_en, 1'b1);
        rst_n = 1;
        @(negedge clk);
        check("R1 after release", spec_en, 1'b1);

        // R8: first pass, no metadata anywhere
        for (int i = 0; i < SLOTS; i++) do_fetch(i, 0, 0, 0, 0, "R8 first pass", 1);
        // R2 / R3: second pass, every fall-through bit learned
        for (int i = 0; i < SLOTS; i++) begin
            do_fetch(i, 0, 0, 0, 0, "R2 second pass", 1);
            check("R3 learned fall-through", spec_en, 1'b0);
        end
        // R2: idle cycles hold the enable
        repeat (3) cycle("R2 hold", 1);

        // R4: counter state sweep for a sequential successor branch
        for (int st = 0; st < 4; st++) begin
            do_fetch(4, 0, 0, 0, 0, "R4", 0);
            do_fetch(5, 1, st, 0, 0, "R4", 0);
            do_fetch(6, 0, 0, 0, 0, "R4", 0);
            do_fetch(4, 0, 0, 0, 0, "R4 state sweep", 1);
            check("R4 literal", spec_en, (st == 0) ? 1'b0 : 1'b1);
        end

        // R5: misprediction clears predecessor, inside a line
        do_fetch(4, 0, 0, 0, 0, "R5", 0);
        do_fetch(5, 1, 0, 0, 0, "R5", 0);
        do_mispred(5);
        do_fetch(4, 0, 0, 0, 0, "R5 in-line", 1);
        check("R5 literal in-line", spec_en, 1'b1);
        // R5: wrap from slot 0 to the last slot
        do_fetch(15, 0, 0, 0, 0, "R5", 0);
        do_fetch(0, 1, 0, 0, 0, "R5", 0);
        do_fetch(15, 0, 0, 0, 0, "R5 before clear", 1);
        do_mispred(0);
        do_fetch(15, 0, 0, 0, 0, "R5 wrap", 1);
        check("R5 literal wrap", spec_en, 1'b1);
        // R5: clear wins over a same-cycle learn
        do_fetch(9, 0, 0, 0, 0, "R5", 0);
        set_fetch(10, 1, 0, 0, 0);
        mispred_vld = 1; mispred_line = 2'd2; mispred_word = 2'd2;
        cycle("R5", 0);
        do_fetch(9, 0, 0, 0, 0, "R5 same cycle", 1);
        check("R5 literal same cycle", spec_en, 1'b1);

        // R6: target bit learning over the counter states
        for (int st = 0; st < 4; st++) begin
            do_fetch(7, 1, 3, 1, 0, "R6", 0);
            do_fetch(12, 1, st, 0, 1, "R6", 0);
            do_fetch(7, 1, 3, 1, 0, "R6 target sweep", 1);
            check("R6 literal", spec_en, (st == 0) ? 1'b0 : 1'b1);
        end

        // R7: independence of the two bits
        do_fetch(7, 1, 3, 1, 0, "R7", 0);
        do_fetch(12, 0, 0, 0, 1, "R7", 0);
        do_fetch(7, 1, 2, 0, 0, "R7", 0);
        do_fetch(8, 1, 2, 0, 0, "R7", 0);
        do_fetch(7, 1, 3, 1, 0, "R7 taken path", 1);
        check("R7 literal taken", spec_en, 1'b0);
        do_fetch(7, 1, 3, 0, 0, "R7 fall path", 1);
        check("R7 literal fall", spec_en, 1'b1);

        // R9: eviction clears, and same-cycle fetch sees cleared bits
        do_fetch(5, 0, 0, 0, 0, "R9", 0);
        do_fetch(6, 0, 0, 0, 0, "R9", 0);
        do_evict(1);
        do_fetch(5, 0, 0, 0, 0, "R9 after evict", 1);
        check("R9 literal", spec_en, 1'b1);
        do_fetch(9, 0, 0, 0, 0, "R9", 0);
        do_fetch(10, 0, 0, 0, 0, "R9", 0);
        set_fetch(9, 0, 0, 0, 0);
        evict_vld = 1; evict_line = 2'd2;
        cycle("R9 same cycle", 1);
        check("R9 literal same cycle", spec_en, 1'b1);

        // R10: other lines survive
        do_fetch(3, 0, 0, 0, 0, "R10", 0);
        do_fetch(4, 0, 0, 0, 0, "R10", 0);
        do_fetch(2, 1, 3, 1, 0, "R10", 0);
        do_fetch(13, 0, 0, 0, 1, "R10", 0);
        do_evict(1);
        do_evict(3);
        do_fetch(3, 0, 0, 0, 0, "R10 line-end bit", 1);
        check("R10 literal line-end", spec_en, 1'b0);
        do_fetch(2, 1, 3, 1, 0, "R10 target bit", 1);
        check("R10 literal target", spec_en, 1'b0);

        // R11: evicting the remembered slot's line forgets it
        do_fetch(5, 0, 0, 0, 0, "R11", 0);
        do_evict(1);
        do_fetch(6, 0, 0, 0, 0, "R11", 0);
        do_fetch(5, 0, 0, 0, 0, "R11 no stale learn", 1);
        check("R11 literal", spec_en, 1'b1);

        // R3: random traffic against the reference state
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(9, 0) < 8) begin
                bit c;
                c = ($urandom_range(9, 0) < 3);
                set_fetch(int'($urandom_range(SLOTS-1, 0)), c, int'($urandom_range(3, 0)),
                          c ? 1'($urandom_range(1, 0)) : 1'b0, ($urandom_range(9, 0) < 3));
            end
            if ($urandom_range(19, 0) == 0) begin
                mispred_vld = 1;
                mispred_line = LINE_W'($urandom_range(LINES-1, 0));
                mispred_word = WORD_W'($urandom_range(WORDS-1, 0));
            end
            if ($urandom_range(19, 0) == 0) begin
                evict_vld = 1;
                evict_line = LINE_W'($urandom_range(LINES-1, 0));
            end
            cycle("R3 random", 1);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule